// File: doc/BRIEF.md
# Serial Byte Receiver with Command/Data Tagging

This block is the receive side of a slave-only synchronous serial link for a display driver. A master drives four lines: a serial clock, a serial data input, an active-low select, and a line that marks each byte as either a command or a data write for display memory. The block brings all four lines into the system clock domain. It shifts in one bit on each rising edge of the serial clock and, after every eighth bit, hands the completed byte on together with its command/data tag.

While the select line is high, the bit counter and the shift register are held cleared. Pulling select high part-way through a byte therefore discards the partial byte. Bytes may follow one another with select held low, and the bit counter wraps after the eighth bit. The command/data line is looked at only on the eighth rising edge of each byte. Its level at any other time has no effect.

Completed bytes leave on a valid/ready stream. The serial master cannot be stalled, so the back-pressure rule is as follows. A byte stays on the output, unchanged, until the consumer accepts it with ready high. If the next byte completes while one is still pending, the newer byte replaces the pending one. The consumer must accept each byte within about eight serial bit times to avoid losing one.

Top module: `dser_byte_rx`

## Requirements
- R1: After reset, rx_valid_o is 0, and it stays 0 until a full byte has been received.
- R2: Eight rising serial-clock edges with select low form one byte, with the first bit received in bit 7 of rx_data_o (MSB first). Falling edges shift nothing.
- R3: rx_is_data_o takes the level of the command/data line at the eighth rising edge of the byte: 0 means command and 1 means display data. Its level on the other seven edges has no effect.
- R4: If select goes high before the eighth edge, the partial byte produces no output. The next byte after select returns low is assembled from a fresh bit count.
- R5: Rising serial-clock edges that occur while select is high produce no byte.
- R6: With select held low, successive groups of eight edges each produce one byte. The bit counter wraps with no gap.
- R7: While rx_valid_o is 1 and rx_ready_i is 0, rx_valid_o stays 1 and rx_data_o and rx_is_data_o do not change, unless a new byte completes.
- R8: A byte that completes while an earlier byte is still pending replaces it, and only the newer byte is delivered.
- R9: rx_valid_o rises no more than 6 system clocks after the system-clock edge at which the completing serial-clock rise is first presented at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the master |
| ser_din_i | input | 1 | Serial data, sampled on the rising serial-clock edge |
| ser_en_n_i | input | 1 | Active-low select; when high, the receiver is held cleared |
| ser_dc_i | input | 1 | Command (0) / display data (1) marker, sampled on the eighth edge |
| rx_valid_o | output | 1 | A received byte is on the output |
| rx_ready_i | input | 1 | Consumer accepts the byte on a clock where valid and ready are both 1 |
| rx_data_o | output | 8 | Received byte, MSB first on the wire |
| rx_is_data_o | output | 1 | Tag of the received byte: 1 for display data, 0 for command |

## Verification
A bit counter that drifts or fails to clear shows up as a byte whose bits are rotated against what was sent. It can also show up as a byte appearing a few serial edges early or late, or as a spurious byte after select has bounced. All of these are visible on the first transfer after the fault. A misplaced command/data sample shows up as a wrong tag, because the bench drives random levels on that line during the first seven bits. A faulty output hold shows up as either a lost byte or a duplicated byte at the next back-pressure episode. A slow path shows up in the fixed latency window checked on a single directed byte.

// File: rtl/dser_pkg.sv
package dser_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] data;
  } dser_byte_t;
endpackage

// File: rtl/dser_sync.sv
module dser_sync #(
  parameter int unsigned       STAGES  = 2,
  parameter int unsigned       WIDTH   = 4,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dser_shifter.sv
module dser_shifter
  import dser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s_i,
  input  logic       sdin_s_i,
  input  logic       en_n_s_i,
  input  logic       dc_s_i,
  output logic       emit_o,
  output dser_byte_t byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_prev;
  logic              sclk_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shreg_nxt;
  logic              emit_q;
  dser_byte_t        byte_q;

  assign sclk_rise = sclk_s_i & ~sclk_prev;
  assign shreg_nxt = {shreg[BYTE_W-2:0], sdin_s_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      emit_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      emit_q <= 1'b0;
      if (en_n_s_i) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (sclk_rise) begin
        shreg <= shreg_nxt;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt        <= '0;
          emit_q         <= 1'b1;
          byte_q.data    <= shreg_nxt;
          byte_q.is_data <= dc_s_i;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign emit_o = emit_q;
  assign byte_o = byte_q;

  AST_CLEAR_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s_i |=> (bit_cnt == '0) && (shreg == '0)); // R4
  AST_NO_EMIT_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_n_s_i) |-> !emit_q); // R5
  AST_WRAP_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    emit_q |-> (bit_cnt == '0)); // R6
endmodule

// File: rtl/dser_outreg.sv
module dser_outreg
  import dser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  dser_byte_t byte_i,
  input  logic       ready_i,
  output logic       valid_o,
  output dser_byte_t byte_o
);
  logic       valid_q;
  dser_byte_t hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hold_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      hold_q  <= byte_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = hold_q;

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i && !load_i) |=> (valid_q && $stable(hold_q))); // R7
  AST_NEWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_q && hold_q == $past(byte_i))); // R8
endmodule

// File: rtl/dser_byte_rx.sv
module dser_byte_rx
  import dser_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  input  logic              ser_en_n_i,
  input  logic              ser_dc_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_is_data_o
);
  localparam int unsigned LINES = 4;
  localparam logic [LINES-1:0] LINE_RST = 4'b0100;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  logic             emit;
  dser_byte_t       shifted;
  dser_byte_t       held;

  assign raw_lines = {ser_dc_i, ser_en_n_i, ser_din_i, ser_clk_i};

  dser_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINES),
    .RST_VAL(LINE_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_lines),
    .q_o  (sync_lines)
  );

  dser_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s_i(sync_lines[0]),
    .sdin_s_i(sync_lines[1]),
    .en_n_s_i(sync_lines[2]),
    .dc_s_i  (sync_lines[3]),
    .emit_o  (emit),
    .byte_o  (shifted)
  );

  dser_outreg u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (emit),
    .byte_i (shifted),
    .ready_i(rx_ready_i),
    .valid_o(rx_valid_o),
    .byte_o (held)
  );

  assign rx_data_o    = held.data;
  assign rx_is_data_o = held.is_data;

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !rx_valid_o); // R1
endmodule

// File: tb/dser_byte_rx_tb.sv
`timescale 1ns/1ps
module dser_byte_rx_tb;
  localparam int HALF = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic       ser_en_n = 1'b1;
  logic       ser_dc = 1'b0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_is_data;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    rdy_force = 1'b1;
  bit    rdy_val = 1'b0;
  string cur_req = "R2";
  logic [8:0] exp_q [$];

  always #4 clk = ~clk;

  dser_byte_rx u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (ser_clk),
    .ser_din_i   (ser_din),
    .ser_en_n_i  (ser_en_n),
    .ser_dc_i    (ser_dc),
    .rx_valid_o  (rx_valid),
    .rx_ready_i  (rx_ready),
    .rx_data_o   (rx_data),
    .rx_is_data_o(rx_is_data)
  );

  function automatic logic [8:0] pack_exp(input logic [7:0] b, input logic dc8);
    return {dc8, b};
  endfunction

  task automatic check(input string req, input bit ok, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rdy_force) rx_ready <= rdy_val;
    else           rx_ready <= ($urandom % 4) != 0;
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) begin
        check(cur_req, 1'b0, {rx_is_data, rx_data}, 9'h000);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check(cur_req, {rx_is_data, rx_data} == e, {rx_is_data, rx_data}, e);
      end
    end
  end

  task automatic ser_bit(input logic b, input logic dc);
    ser_din = b;
    ser_dc  = dc;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic dc8);
    for (int i = 7; i >= 1; i--) ser_bit(b[i], 1'($urandom % 2));
    ser_bit(b[0], dc8);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] a;
    logic [7:0] b;
    void'($urandom(32'h00C0FFEE));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", rx_valid == 1'b0, {8'h0, rx_valid}, 9'h000);

    // R3: command/data line high on the first seven bits, low on the eighth
    ser_en_n = 1'b0;
    rdy_force = 1'b0;
    cur_req = "R3";
    exp_q.push_back(pack_exp(8'hA5, 1'b0));
    for (int i = 7; i >= 1; i--) ser_bit(a_bit(8'hA5, i), 1'b1);
    ser_bit(1'b1, 1'b0);
    exp_q.push_back(pack_exp(8'h3C, 1'b1));
    for (int i = 7; i >= 1; i--) ser_bit(a_bit(8'h3C, i), 1'b0);
    ser_bit(1'b0, 1'b1);
    repeat (20) @(negedge clk);

    // R9: latency of one byte with ready held low
    rdy_force = 1'b1;
    rdy_val = 1'b0;
    cur_req = "R9";
    repeat (4) @(negedge clk);
    exp_q.push_back(pack_exp(8'h81, 1'b1));
    for (int i = 7; i >= 1; i--) ser_bit(a_bit(8'h81, i), 1'b0);
    repeat (8) @(negedge clk);
    check("R9", rx_valid == 1'b0, {8'h0, rx_valid}, 9'h000);
    ser_din = 1'b1;
    ser_dc = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b1;
    repeat (6) @(negedge clk);
    check("R9", rx_valid == 1'b1, {8'h0, rx_valid}, 9'h001);
    ser_clk = 1'b0;
    rdy_val = 1'b1;
    repeat (4) @(negedge clk);
    rdy_val = 1'b0;

    // R7 and R8: hold under back-pressure, then a newer byte replaces it
    cur_req = "R8";
    a = 8'h5A;
    b = 8'hC3;
    send_byte(a, 1'b0);
    repeat (10) @(negedge clk);
    begin
      bit stable_ok = 1'b1;
      for (int i = 0; i < 10; i++) begin
        if (!(rx_valid && rx_data == a && !rx_is_data)) stable_ok = 1'b0;
        @(negedge clk);
      end
      check("R7", stable_ok, {rx_is_data, rx_data}, pack_exp(a, 1'b0));
    end
    send_byte(b, 1'b1);
    repeat (10) @(negedge clk);
    check("R8", rx_valid && rx_data == b && rx_is_data, {rx_is_data, rx_data}, pack_exp(b, 1'b1));
    exp_q.push_back(pack_exp(b, 1'b1));
    rdy_force = 1'b0;
    repeat (20) @(negedge clk);

    // R4: select rises after five bits
    cur_req = "R4";
    for (int i = 0; i < 5; i++) ser_bit(1'b1, 1'b1);
    ser_en_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R4", rx_valid == 1'b0, {8'h0, rx_valid}, 9'h000);

    // R5: serial edges while select is high
    cur_req = "R5";
    for (int i = 0; i < 8; i++) ser_bit(1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check("R5", rx_valid == 1'b0, {8'h0, rx_valid}, 9'h000);
    ser_en_n = 1'b0;
    repeat (10) @(negedge clk);
    cur_req = "R4";
    exp_q.push_back(pack_exp(8'h0F, 1'b0));
    send_byte(8'h0F, 1'b0);
    repeat (20) @(negedge clk);

    // R2 and R6: random bytes, mostly back to back, with occasional select gaps
    cur_req = "R6";
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic       t;
      d = 8'($urandom);
      t = 1'($urandom % 2);
      exp_q.push_back(pack_exp(d, t));
      send_byte(d, t);
      if (($urandom % 5) == 0) begin
        repeat (6) @(negedge clk);
        ser_en_n = 1'b1;
        repeat (8) @(negedge clk);
        ser_en_n = 1'b0;
        repeat (6) @(negedge clk);
      end
    end
    rdy_force = 1'b1;
    rdy_val = 1'b1;
    repeat (30) @(negedge clk);
    check("R2", exp_q.size() == 0, 9'(exp_q.size()), 9'h000);
    finish_run();
  end

  function automatic logic a_bit(input logic [7:0] v, input int i);
    return v[i];
  endfunction
endmodule